// File: doc/BRIEF.md
# Serial BLAKE-256 Compression Round Engine

This block computes one BLAKE-256 compression on a 4x4 array of 32-bit working words. A single half-G circuit is shared across every G application. A host streams in, one word per accepted cycle, the chain value, the salt, the two counter halves and the sixteen message words. The block then runs all rounds on its own and returns the eight words of the next chain value on consecutive cycles. On the last block of a message, those eight words are the digest.

Each round spends eight cycles on the four columns and then eight cycles on the four disjoint diagonals. Every G is split into a first-half pass and a second-half pass, so a round takes sixteen cycles. The pass order is arranged so that the result is identical to a fully parallel evaluation. Padding and tracking the message length stay with the host, which supplies the counter value for each block.

Top module: `blake_round_engine`

## Requirements
- R1: Out of reset, `busy` and `out_valid` are low and `out_word` is zero.
- R2: While `busy` is low, a word is taken only in a cycle where `load_valid` is high, and idle cycles in between are allowed. The 30 words arrive in this fixed order: chain words h0..h7, salt words s0..s3, counter low word t0, counter high word t1, then message words m0..m15. `busy` stays low until the 30th word is taken and is high in the cycle after it.
- R3: While the message words arrive, working word i is set as follows: h_i for i<8, s_(i-8) XOR k_(i-8) for i=8..11, t0 XOR k_(i-8) for i=12,13, and t1 XOR k_(i-8) for i=14,15. Here k_0..k_15 are the standard BLAKE-256 constants.
- R4: Each round applies G0..G3 to the columns (words j, 4+j, 8+j, 12+j) and then G4..G7 to the diagonals (words j, 4+(j+1)%4, 8+(j+2)%4, 12+(j+3)%4). G_i mixes message words m_sigma(2i) and m_sigma(2i+1), where sigma is the permutation row of round index mod 10. Every half pass writes exactly four distinct working words.
- R5: The first half of G_i adds m_sigma(2i) XOR k_sigma(2i+1) and rotates right by 16 and then by 12. The second half adds m_sigma(2i+1) XOR k_sigma(2i) and rotates right by 8 and then by 7.
- R6: There are NUM_ROUNDS rounds of 16 cycles each. `out_valid` first rises exactly NUM_ROUNDS*16 cycles after the cycle in which the 30th word was taken.
- R7: `out_valid` stays high for exactly 8 consecutive cycles. In cycle n of that window (n = 0..7), `out_word` carries h_n XOR s_(n mod 4) XOR v_n XOR v_(n+8). After the window, `busy` falls.
- R8: While `busy` is high, `load_valid` and `load_data` have no effect on the result. The next block is taken once `busy` is low.
- R9: `out_word` is zero whenever `out_valid` is low.
- R10: With the standard initial chain value, zero salt, counter 8 and the single padded block of one zero byte, the output is the published BLAKE-256 digest of that message.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously |
| load_valid | input | 1 | Offers `load_data` as the next input word |
| load_data | input | 32 | Input word (chain, salt, counter, message order) |
| busy | output | 1 | High from the end of loading until the last output word |
| out_valid | output | 1 | Output window, 8 cycles |
| out_word | output | 32 | Next chain value word, zero outside the window |

## Verification
The bench builds the engine with the default of fourteen rounds. With fourteen rounds the permutation row counter wraps past its tenth row, so rounds 10 to 13 reuse rows 0 to 3, and the 224-cycle run window can be timed against the first output word. A published one-byte digest anchors the arithmetic. The remaining blocks, which use arbitrary words, non-zero salts and a non-zero high counter word, are compared against an independent parallel model. They also cover load streams with gaps and traffic that tries to load while the engine is busy.

// File: rtl/blake_rnd_pkg.sv
package blake_rnd_pkg;
  localparam int WW         = 32;
  localparam int N_V        = 16;
  localparam int N_H        = 8;
  localparam int N_S        = 4;
  localparam int N_T        = 2;
  localparam int N_M        = 16;
  localparam int N_LOAD     = N_H + N_S + N_T + N_M;
  localparam int MSG_BASE   = N_H + N_S + N_T;
  localparam int STEPS      = 16;
  localparam int SIGMA_ROWS = 10;

  typedef logic [WW-1:0] word_t;
  typedef enum logic [1:0] {PH_LOAD = 2'd0, PH_RUN = 2'd1, PH_OUT = 2'd2} phase_e;

  function automatic word_t kconst(input logic [3:0] idx);
    word_t r;
    case (idx)
      4'd0:    r = 32'h243F6A88;
      4'd1:    r = 32'h85A308D3;
      4'd2:    r = 32'h13198A2E;
      4'd3:    r = 32'h03707344;
      4'd4:    r = 32'hA4093822;
      4'd5:    r = 32'h299F31D0;
      4'd6:    r = 32'h082EFA98;
      4'd7:    r = 32'hEC4E6C89;
      4'd8:    r = 32'h452821E6;
      4'd9:    r = 32'h38D01377;
      4'd10:   r = 32'hBE5466CF;
      4'd11:   r = 32'h34E90C6C;
      4'd12:   r = 32'hC0AC29B7;
      4'd13:   r = 32'hC97C50DD;
      4'd14:   r = 32'h3F84D5B5;
      default: r = 32'hB5470917;
    endcase
    return r;
  endfunction

  // permutation rows, position 0 in the top nibble
  function automatic logic [63:0] sigma_row(input logic [3:0] row);
    logic [63:0] r;
    case (row)
      4'd1:    r = 64'hEA489FD61C02B753;
      4'd2:    r = 64'hB8C052FDAE367194;
      4'd3:    r = 64'h7931DCBE265A40F8;
      4'd4:    r = 64'h905724AFE1BC683D;
      4'd5:    r = 64'h2C6A0B834D75FE19;
      4'd6:    r = 64'hC51FED4A0763928B;
      4'd7:    r = 64'hDB7EC13950F4862A;
      4'd8:    r = 64'h6FE9B308C2D714A5;
      4'd9:    r = 64'hA2847615FB9E3CD0;
      default: r = 64'h0123456789ABCDEF;
    endcase
    return r;
  endfunction

  function automatic logic [3:0] sigma(input logic [3:0] row, input logic [3:0] pos);
    logic [63:0] r;
    int p;
    r = sigma_row(row);
    p = 15 - int'(pos);
    return r[4*p +: 4];
  endfunction

  function automatic word_t rotr(input word_t x, input int n);
    return (x >> n) | (x << (WW - n));
  endfunction
endpackage

// File: rtl/blake_rnd_seq.sv
module blake_rnd_seq
  import blake_rnd_pkg::*;
#(
  parameter int NUM_ROUNDS = 14
) (
  input  logic                       clk,
  input  logic                       rst_n,
  input  logic                       load_fire,
  output phase_e                     phase_o,
  output logic [$clog2(N_LOAD)-1:0]  wcnt_o,
  output logic [3:0]                 step_o,
  output logic [3:0]                 srow_o,
  output logic [2:0]                 ocnt_o
);
  localparam int WCW = $clog2(N_LOAD);
  localparam int RW  = (NUM_ROUNDS > 1) ? $clog2(NUM_ROUNDS) : 1;

  phase_e           phase_q, phase_d;
  logic [WCW-1:0]   wcnt_q, wcnt_d;
  logic [3:0]       step_q, step_d;
  logic [RW-1:0]    rnd_q, rnd_d;
  logic [3:0]       srow_q, srow_d;
  logic [2:0]       ocnt_q, ocnt_d;
  logic             seq_en;

  assign seq_en = load_fire || (phase_q != PH_LOAD);

  always_comb begin
    phase_d = phase_q;
    wcnt_d  = wcnt_q;
    step_d  = step_q;
    rnd_d   = rnd_q;
    srow_d  = srow_q;
    ocnt_d  = ocnt_q;
    case (phase_q)
      PH_LOAD: begin
        if (wcnt_q == WCW'(N_LOAD - 1)) begin
          wcnt_d  = '0;
          phase_d = PH_RUN;
          step_d  = '0;
          rnd_d   = '0;
          srow_d  = '0;
        end else begin
          wcnt_d = wcnt_q + 1'b1;
        end
      end
      PH_RUN: begin
        step_d = step_q + 1'b1;
        if (step_q == 4'(STEPS - 1)) begin
          if (rnd_q == RW'(NUM_ROUNDS - 1)) begin
            phase_d = PH_OUT;
            ocnt_d  = '0;
          end else begin
            rnd_d  = rnd_q + 1'b1;
            srow_d = (srow_q == 4'(SIGMA_ROWS - 1)) ? 4'd0 : srow_q + 1'b1;
          end
        end
      end
      PH_OUT: begin
        ocnt_d = ocnt_q + 1'b1;
        if (ocnt_q == 3'd7) phase_d = PH_LOAD;
      end
      default: phase_d = PH_LOAD;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      phase_q <= PH_LOAD;
      wcnt_q  <= '0;
      step_q  <= '0;
      rnd_q   <= '0;
      srow_q  <= '0;
      ocnt_q  <= '0;
    end else if (seq_en) begin
      phase_q <= phase_d;
      wcnt_q  <= wcnt_d;
      step_q  <= step_d;
      rnd_q   <= rnd_d;
      srow_q  <= srow_d;
      ocnt_q  <= ocnt_d;
    end
  end

  assign phase_o = phase_q;
  assign wcnt_o  = wcnt_q;
  assign step_o  = step_q;
  assign srow_o  = srow_q;
  assign ocnt_o  = ocnt_q;

  // R2
  load_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (phase_q == PH_LOAD && !load_fire) |=> (phase_q == PH_LOAD && $stable(wcnt_q)));

  // R7
  out_span_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (phase_q == PH_OUT && ocnt_q != 3'd7) |=> (phase_q == PH_OUT));

  // R4
  row_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
    srow_q < 4'(SIGMA_ROWS));
endmodule

// File: rtl/blake_rnd_loadbank.sv
module blake_rnd_loadbank
  import blake_rnd_pkg::*;
(
  input  logic                              clk,
  input  logic                              wr_en,
  input  logic [$clog2(N_LOAD)-1:0]         wr_idx,
  input  word_t                             wr_data,
  output logic [N_LOAD-1:0][WW-1:0]         bank_o
);
  localparam int WCW = $clog2(N_LOAD);

  for (genvar k = 0; k < N_LOAD; k++) begin : g_slot
    word_t slot_q;
    logic  slot_en;
    assign slot_en = wr_en && (wr_idx == WCW'(k));
    always_ff @(posedge clk) begin
      if (slot_en) slot_q <= wr_data;
    end
    assign bank_o[k] = slot_q;
  end
endmodule

// File: rtl/blake_rnd_halfg.sv
module blake_rnd_halfg
  import blake_rnd_pkg::*;
#(
  parameter int ROT_A0 = 16,
  parameter int ROT_B0 = 12,
  parameter int ROT_A1 = 8,
  parameter int ROT_B1 = 7
) (
  input  word_t a_i,
  input  word_t b_i,
  input  word_t c_i,
  input  word_t d_i,
  input  word_t mk_i,
  input  logic  second_i,
  output word_t a_o,
  output word_t b_o,
  output word_t c_o,
  output word_t d_o
);
  word_t a1, dx, d1, c1, bx, b1;

  always_comb begin
    a1 = a_i + b_i + mk_i;
    dx = d_i ^ a1;
    d1 = second_i ? rotr(dx, ROT_A1) : rotr(dx, ROT_A0);
    c1 = c_i + d1;
    bx = b_i ^ c1;
    b1 = second_i ? rotr(bx, ROT_B1) : rotr(bx, ROT_B0);
  end

  assign a_o = a1;
  assign b_o = b1;
  assign c_o = c1;
  assign d_o = d1;
endmodule

// File: rtl/blake_rnd_vstate.sv
module blake_rnd_vstate
  import blake_rnd_pkg::*;
(
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     init_we,
  input  logic [3:0]               init_idx,
  input  word_t                    init_word,
  input  logic                     run_en,
  input  logic [3:0]               step,
  input  word_t                    a_n,
  input  word_t                    b_n,
  input  word_t                    c_n,
  input  word_t                    d_n,
  output word_t                    qa,
  output word_t                    qb,
  output word_t                    qc,
  output word_t                    qd,
  output logic [N_V-1:0][WW-1:0]   v_o
);
  logic [1:0]     g;
  logic           diag;
  logic [3:0]     ia, ib, ic, id;
  word_t          v_q [N_V];
  logic [N_V-1:0] we_vec;

  assign g    = step[2:1];
  assign diag = step[3];

  always_comb begin
    ia = {2'b00, g};
    ib = {2'b01, diag ? g + 2'd1 : g};
    ic = {2'b10, diag ? g + 2'd2 : g};
    id = {2'b11, diag ? g + 2'd3 : g};
  end

  for (genvar k = 0; k < N_V; k++) begin : g_word
    logic  we;
    word_t nxt;
    always_comb begin
      we  = 1'b0;
      nxt = v_q[k];
      if (init_we && init_idx == 4'(k)) begin
        we  = 1'b1;
        nxt = init_word;
      end else if (run_en) begin
        if (ia == 4'(k)) begin
          we = 1'b1; nxt = a_n;
        end else if (ib == 4'(k)) begin
          we = 1'b1; nxt = b_n;
        end else if (ic == 4'(k)) begin
          we = 1'b1; nxt = c_n;
        end else if (id == 4'(k)) begin
          we = 1'b1; nxt = d_n;
        end
      end
    end
    always_ff @(posedge clk) begin
      if (we) v_q[k] <= nxt;
    end
    assign we_vec[k] = we;
    assign v_o[k]    = v_q[k];
  end

  assign qa = v_q[ia];
  assign qb = v_q[ib];
  assign qc = v_q[ic];
  assign qd = v_q[id];

  // R4
  four_words_chk: assert property (@(posedge clk) disable iff (!rst_n)
    run_en |-> ($countones(we_vec) == 4));

  // R3
  init_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
    init_we |-> $onehot0(we_vec));
endmodule

// File: rtl/blake_round_engine.sv
module blake_round_engine
  import blake_rnd_pkg::*;
#(
  parameter int NUM_ROUNDS = 14
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        load_valid,
  input  logic [31:0] load_data,
  output logic        busy,
  output logic        out_valid,
  output logic [31:0] out_word
);
  localparam int WCW     = $clog2(N_LOAD);
  localparam int RUN_CYC = NUM_ROUNDS * STEPS;
  localparam int RCW     = $clog2(RUN_CYC + 1);

  phase_e                   phase;
  logic [WCW-1:0]           wcnt;
  logic [3:0]               step, srow;
  logic [2:0]               ocnt;
  logic                     load_fire, run_en, init_we;
  logic [3:0]               init_idx;
  word_t                    init_word;
  logic [N_LOAD-1:0][WW-1:0] bank;
  logic [N_H-1:0][WW-1:0]   chain;
  logic [N_S-1:0][WW-1:0]   salt;
  logic [N_M-1:0][WW-1:0]   msg;
  word_t                    t_lo, t_hi;
  logic [N_V-1:0][WW-1:0]   v;
  word_t                    qa, qb, qc, qd, a_n, b_n, c_n, d_n, mk;
  logic [2:0]               gi;
  logic [3:0]               s_even, s_odd, m_idx, k_idx;

  assign load_fire = load_valid && (phase == PH_LOAD);
  assign run_en    = (phase == PH_RUN);
  assign busy      = (phase != PH_LOAD);
  assign out_valid = (phase == PH_OUT);

  blake_rnd_seq #(.NUM_ROUNDS(NUM_ROUNDS)) seq_i (
    .clk(clk), .rst_n(rst_n), .load_fire(load_fire), .phase_o(phase),
    .wcnt_o(wcnt), .step_o(step), .srow_o(srow), .ocnt_o(ocnt)
  );

  blake_rnd_loadbank bank_i (
    .clk(clk), .wr_en(load_fire), .wr_idx(wcnt), .wr_data(load_data), .bank_o(bank)
  );

  for (genvar k = 0; k < N_H; k++) begin : g_chain
    assign chain[k] = bank[k];
  end
  for (genvar k = 0; k < N_S; k++) begin : g_salt
    assign salt[k] = bank[N_H + k];
  end
  for (genvar k = 0; k < N_M; k++) begin : g_msg
    assign msg[k] = bank[MSG_BASE + k];
  end
  assign t_lo = bank[N_H + N_S];
  assign t_hi = bank[N_H + N_S + 1];

  // working word i is formed while message word i arrives
  assign init_we  = load_fire && (wcnt >= WCW'(MSG_BASE));
  assign init_idx = 4'(wcnt - WCW'(MSG_BASE));

  always_comb begin
    if (!init_idx[3])
      init_word = chain[init_idx[2:0]];
    else if (!init_idx[2])
      init_word = salt[init_idx[1:0]] ^ kconst({2'b00, init_idx[1:0]});
    else if (!init_idx[1])
      init_word = t_lo ^ kconst({2'b01, init_idx[1:0]});
    else
      init_word = t_hi ^ kconst({2'b01, init_idx[1:0]});
  end

  // message and constant selection for the current half pass
  always_comb begin
    gi     = {step[3], step[2:1]};
    s_even = sigma(srow, {gi, 1'b0});
    s_odd  = sigma(srow, {gi, 1'b1});
    m_idx  = step[0] ? s_odd : s_even;
    k_idx  = step[0] ? s_even : s_odd;
    mk     = msg[m_idx] ^ kconst(k_idx);
  end

  blake_rnd_vstate vstate_i (
    .clk(clk), .rst_n(rst_n), .init_we(init_we), .init_idx(init_idx),
    .init_word(init_word), .run_en(run_en), .step(step),
    .a_n(a_n), .b_n(b_n), .c_n(c_n), .d_n(d_n),
    .qa(qa), .qb(qb), .qc(qc), .qd(qd), .v_o(v)
  );

  blake_rnd_halfg halfg_i (
    .a_i(qa), .b_i(qb), .c_i(qc), .d_i(qd), .mk_i(mk), .second_i(step[0]),
    .a_o(a_n), .b_o(b_n), .c_o(c_n), .d_o(d_n)
  );

  assign out_word = out_valid
                  ? (chain[ocnt] ^ salt[ocnt[1:0]] ^ v[{1'b0, ocnt}] ^ v[{1'b1, ocnt}])
                  : '0;

  logic [RCW-1:0] chk_run_q;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)          chk_run_q <= '0;
    else if (!busy)      chk_run_q <= '0;
    else if (!out_valid) chk_run_q <= chk_run_q + 1'b1;
  end

  // R6
  run_cycles_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(out_valid) |-> (chk_run_q == RCW'(RUN_CYC)));

  // R8
  msg_frozen_chk: assert property (@(posedge clk) disable iff (!rst_n)
    busy |=> $stable(msg));

  // R7
  out_in_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid |-> busy);

  // R7
  busy_drop_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(out_valid) |-> !busy);
endmodule

// File: tb/blake_round_engine_tb_top.sv
`timescale 1ns/1ps
module blake_round_engine_tb_top;
  typedef logic [31:0] w_t;
  typedef struct {
    w_t    w;
    string req;
  } exp_t;

  logic clk, rst_n, load_valid, busy, out_valid;
  logic [31:0] load_data, out_word;

  int   n_chk  = 0;
  int   n_fail = 0;
  int   cyc    = 0;
  int   t_load = 0;
  int   run_len = 0;
  bit   finished = 0;
  exp_t sb[$];

  blake_round_engine dut_i (
    .clk(clk), .rst_n(rst_n), .load_valid(load_valid), .load_data(load_data),
    .busy(busy), .out_valid(out_valid), .out_word(out_word)
  );

  initial clk = 1'b0;
  always #2 clk = ~clk;
  always @(posedge clk) cyc++;

  task automatic check(input bit ok, input string req, input string what,
                       input w_t act, input w_t exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s: actual %08h expected %08h", req, what, act, exp);
    end
  endtask

  // independent parallel model of one compression
  function automatic w_t ror(input w_t x, input int n);
    logic [63:0] xx;
    xx = {x, x} >> n;
    return xx[31:0];
  endfunction

  function automatic int sg(input int r, input int j);
    logic [63:0] rows [10];
    rows = '{64'h0123456789ABCDEF, 64'hEA489FD61C02B753, 64'hB8C052FDAE367194,
             64'h7931DCBE265A40F8, 64'h905724AFE1BC683D, 64'h2C6A0B834D75FE19,
             64'hC51FED4A0763928B, 64'hDB7EC13950F4862A, 64'h6FE9B308C2D714A5,
             64'hA2847615FB9E3CD0};
    return int'(rows[r % 10][4*(15-j) +: 4]);
  endfunction

  function automatic void ref_hash(input w_t wv[30], output w_t o[8]);
    w_t kc [16];
    w_t v [16];
    kc = '{32'h243F6A88, 32'h85A308D3, 32'h13198A2E, 32'h03707344,
           32'hA4093822, 32'h299F31D0, 32'h082EFA98, 32'hEC4E6C89,
           32'h452821E6, 32'h38D01377, 32'hBE5466CF, 32'h34E90C6C,
           32'hC0AC29B7, 32'hC97C50DD, 32'h3F84D5B5, 32'hB5470917};
    for (int i = 0; i < 8; i++) v[i] = wv[i];
    for (int i = 0; i < 4; i++) v[8+i] = wv[8+i] ^ kc[i];
    v[12] = wv[12] ^ kc[4];
    v[13] = wv[12] ^ kc[5];
    v[14] = wv[13] ^ kc[6];
    v[15] = wv[13] ^ kc[7];
    for (int r = 0; r < 14; r++) begin
      for (int i = 0; i < 8; i++) begin
        int ai, bi, ci, di, x, y;
        if (i < 4) begin
          ai = i; bi = 4 + i; ci = 8 + i; di = 12 + i;
        end else begin
          ai = i - 4; bi = 4 + (i - 3) % 4; ci = 8 + (i - 2) % 4; di = 12 + (i - 1) % 4;
        end
        x = sg(r, 2*i);
        y = sg(r, 2*i + 1);
        v[ai] = v[ai] + v[bi] + (wv[14+x] ^ kc[y]);
        v[di] = ror(v[di] ^ v[ai], 16);
        v[ci] = v[ci] + v[di];
        v[bi] = ror(v[bi] ^ v[ci], 12);
        v[ai] = v[ai] + v[bi] + (wv[14+y] ^ kc[x]);
        v[di] = ror(v[di] ^ v[ai], 8);
        v[ci] = v[ci] + v[di];
        v[bi] = ror(v[bi] ^ v[ci], 7);
      end
    end
    for (int i = 0; i < 8; i++) o[i] = wv[i] ^ wv[8 + i % 4] ^ v[i] ^ v[i+8];
  endfunction

  // driver: pushes expected words, then streams the block in
  task automatic drive_block(input w_t wv[30], input w_t ex[8], input string req,
                             input bit gaps, input bit junk);
    for (int i = 0; i < 8; i++) begin
      exp_t e;
      e.w = ex[i];
      e.req = req;
      sb.push_back(e);
    end
    for (int k = 0; k < 30; k++) begin
      if (gaps && (k % 3 == 1)) begin
        @(negedge clk);
        load_valid = 1'b0;
        load_data  = $urandom;
      end
      @(negedge clk);
      if (k == 29) check(busy == 1'b0, "R2", "busy before last word", {31'b0, busy}, 32'd0);
      load_valid = 1'b1;
      load_data  = wv[k];
    end
    @(negedge clk);
    t_load = cyc;
    check(busy == 1'b1, "R2", "busy after last word", {31'b0, busy}, 32'd1);
    load_valid = junk;
    load_data  = $urandom;
    while (busy) begin
      @(negedge clk);
      if (busy) begin
        load_valid = junk;
        load_data  = $urandom;
      end else begin
        load_valid = 1'b0;
      end
    end
  endtask

  // monitor: pops expected words as the output window runs
  always @(negedge clk) begin
    if (rst_n) begin
      if (out_valid) begin
        run_len++;
        if (run_len == 1)
          check(cyc - t_load == 224, "R6", "cycles to first output", w_t'(cyc - t_load), 32'd224);
        if (sb.size() == 0) begin
          check(1'b0, "R7", "unexpected output word", out_word, 32'd0);
        end else begin
          exp_t e;
          e = sb.pop_front();
          check(out_word === e.w, e.req, "output word", out_word, e.w);
        end
      end else begin
        if (run_len != 0) begin
          check(run_len == 8, "R7", "window length", w_t'(run_len), 32'd8);
          run_len = 0;
        end
        check(out_word == 32'd0, "R9", "idle output", out_word, 32'd0);
      end
    end
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      check(1'b0, "WDOG", "watchdog expired", 32'd0, 32'd1);
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end

  initial begin
    w_t wv [30];
    w_t ex [8];
    rst_n      = 1'b0;
    load_valid = 1'b0;
    load_data  = '0;
    repeat (3) @(negedge clk);
    // R1
    check(busy == 1'b0, "R1", "busy in reset", {31'b0, busy}, 32'd0);
    check(out_valid == 1'b0, "R1", "out_valid in reset", {31'b0, out_valid}, 32'd0);
    check(out_word == 32'd0, "R1", "out_word in reset", out_word, 32'd0);
    rst_n = 1'b1;
    repeat (2) @(negedge clk);
    check(busy == 1'b0, "R1", "busy after reset", {31'b0, busy}, 32'd0);

    // R10: one zero byte, standard initial value, counter 8
    wv = '{32'h6A09E667, 32'hBB67AE85, 32'h3C6EF372, 32'hA54FF53A,
           32'h510E527F, 32'h9B05688C, 32'h1F83D9AB, 32'h5BE0CD19,
           32'h0, 32'h0, 32'h0, 32'h0, 32'd8, 32'h0,
           32'h00800000, 32'h0, 32'h0, 32'h0, 32'h0, 32'h0, 32'h0, 32'h0,
           32'h0, 32'h0, 32'h0, 32'h0, 32'h0, 32'h00000001, 32'h0, 32'd8};
    ex = '{32'h0CE8D4EF, 32'h4DD7CD8D, 32'h62DFDED9, 32'hD4EDB0A7,
           32'h74AE6A41, 32'h929A74DA, 32'h23109E8F, 32'h11139C87};
    drive_block(wv, ex, "R10", 1'b0, 1'b0);

    // R3 R4 R5: non-zero salt and high counter word, arbitrary message
    for (int k = 0; k < 30; k++) wv[k] = 32'h9E3779B9 * (k + 1) ^ (32'h01010101 << (k % 8));
    ref_hash(wv, ex);
    drive_block(wv, ex, "R3", 1'b0, 1'b0);

    // R2: gaps in the load stream
    for (int k = 0; k < 30; k++) wv[k] = $urandom;
    ref_hash(wv, ex);
    drive_block(wv, ex, "R2", 1'b1, 1'b0);

    // R8: load attempts while busy must not disturb the block
    for (int k = 0; k < 30; k++) wv[k] = $urandom;
    ref_hash(wv, ex);
    drive_block(wv, ex, "R8", 1'b0, 1'b1);

    // R8: block taken right after busy falls; R5 with all-ones words
    for (int k = 0; k < 30; k++) wv[k] = 32'hFFFFFFFF;
    ref_hash(wv, ex);
    drive_block(wv, ex, "R5", 1'b0, 1'b0);

    repeat (4) @(negedge clk);
    check(sb.size() == 0, "R7", "words left in scoreboard", w_t'(sb.size()), 32'd0);
    finished = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule